// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block turns the read-back divider settings of a clock synthesiser into an output frequency in hertz. The caller presents a divider word carrying the feedback multiplier M, the pre-divider P and the post-scaler exponent S. It also presents a fraction word carrying a signed 16-bit fraction K, the reference frequency in hertz and a mode bit, and then pulses a start strobe. The block captures the operands on the start edge, forms a 64-bit numerator and a denominator, and runs a restoring shift-subtract divider that retires one quotient bit per clock. When the divider finishes, the block reports the truncated quotient with a one-cycle done pulse.

In integer mode the multiplier is M alone and the denominator is P shifted left by S. In fractional mode the multiplier is the fixed-point value M·65536 + K, and the denominator is P·65536 shifted left by S. Two operand faults are caught before the divider starts, and each is reported on the very next cycle. A zero pre-divider raises the error output. A negative fractional multiplier gives a result of zero.

The controller has two states. CALC_IDLE waits for start. CALC_DIVIDE waits for the divider to finish. There are four transitions. IDLE to DIVIDE is taken on an accepted start with valid operands (launch). IDLE stays IDLE on a start with a fault, which is reported at once (fault report). DIVIDE to IDLE is taken when the divider finishes, which is reported (result report). Each state otherwise holds (wait).

Top module: `pll_freq_calc`

## Requirements
- R1: M is bits 21:12, P is bits 9:4 and S is bits 2:0 of div_word, and K is bits 15:0 of frac_word. All other bits of both words have no effect on the result.
- R2: With frac_mode = 0, the result is floor(ref_hz·M / (P << S)), and frac_word has no effect.
- R3: With frac_mode = 1, the result is floor(ref_hz·(M·65536 + K) / ((P·65536) << S)), where K is a two's-complement signed 16-bit value.
- R4: For an accepted start with valid operands, done is high in exactly one cycle, 65 clock edges after the start edge. freq_hz carries the new result and err is low in that same cycle.
- R5: An accepted start with P = 0 does not start the divider. On the next cycle done and err are both high and freq_hz is zero.
- R6: In fractional mode, when M·65536 + K is negative, the divider is not started. On the next cycle done is high, err is low and freq_hz is zero.
- R7: A start that arrives while a calculation is in progress is ignored. This includes a start on the edge where the result is reported. The pending result is unchanged.
- R8: After reset, done, err and freq_hz are all zero. freq_hz and err hold their values between reports.
- R9: With the largest operands (ref_hz = 2^32−1, M = 1023, K = 32767, P = 1, S = 0), the result is exact, with no overflow of the numerator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only while idle |
| frac_mode | input | 1 | 0 = integer mode, 1 = fractional mode |
| div_word | input | 32 | Divider word carrying M, P and S |
| frac_word | input | 32 | Fraction word carrying signed K |
| ref_hz | input | 32 | Reference frequency in Hz |
| freq_hz | output | 64 | Computed output frequency in Hz |
| done | output | 1 | One-cycle pulse when a result is reported |
| err | output | 1 | High with the report when P was zero |

## Verification
The two functions that can share a cycle are the result report at the end of a division and the acceptance of a new start. A start that is held on the exact edge where the divider finishes must be ignored, and only a start on a later cycle may launch. The bench provokes this by timing a start strobe 64 and 65 edges after a launch, and also by firing a zero-P start in the middle of a division. It judges the outcome with a behavioural model that predicts done, err and freq_hz on every clock, so a start that is wrongly taken shows up as an early or extra done pulse or as a wrong value.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int PFC_WORD_W     = 32;
    localparam int PFC_M_W        = 10;
    localparam int PFC_M_LSB      = 12;
    localparam int PFC_P_W        = 6;
    localparam int PFC_P_LSB      = 4;
    localparam int PFC_S_W        = 3;
    localparam int PFC_S_LSB      = 0;
    localparam int PFC_K_W        = 16;
    localparam int PFC_FRAC_SHIFT = 16;
    localparam int PFC_NUM_W      = 64;

    typedef enum logic [0:0] {
        CALC_IDLE   = 1'b0,
        CALC_DIVIDE = 1'b1
    } calc_state_e;
endpackage

// File: rtl/pfc_operand_prep.sv
module pfc_operand_prep
    import pfc_pkg::*;
#(
    parameter int WORD_W     = PFC_WORD_W,
    parameter int M_W        = PFC_M_W,
    parameter int M_LSB      = PFC_M_LSB,
    parameter int P_W        = PFC_P_W,
    parameter int P_LSB      = PFC_P_LSB,
    parameter int S_W        = PFC_S_W,
    parameter int S_LSB      = PFC_S_LSB,
    parameter int K_W        = PFC_K_W,
    parameter int FRAC_SHIFT = PFC_FRAC_SHIFT,
    parameter int NUM_W      = PFC_NUM_W,
    localparam int DEN_W     = P_W + FRAC_SHIFT + (2**S_W) - 1
) (
    input  logic              frac_mode,
    input  logic [WORD_W-1:0] div_word,
    input  logic [WORD_W-1:0] frac_word,
    input  logic [WORD_W-1:0] ref_hz,
    output logic [NUM_W-1:0]  numer,
    output logic [DEN_W-1:0]  denom,
    output logic              p_zero,
    output logic              coef_neg
);
    localparam int COEF_W = M_W + FRAC_SHIFT + 1;
    localparam int PS_W   = P_W + FRAC_SHIFT;

    logic [M_W-1:0]    m_fld;
    logic [P_W-1:0]    p_fld;
    logic [S_W-1:0]    s_fld;
    logic [K_W-1:0]    k_fld;
    logic [COEF_W-1:0] k_ext;
    logic [COEF_W-1:0] coef_frac;
    logic [COEF_W-2:0] coef_mag;
    logic [PS_W-1:0]   p_scaled;

    assign m_fld = div_word[M_LSB +: M_W];
    assign p_fld = div_word[P_LSB +: P_W];
    assign s_fld = div_word[S_LSB +: S_W];
    assign k_fld = frac_word[K_W-1:0];

    // Sign-extend K to the coefficient width; two's-complement sum wraps correctly.
    assign k_ext     = {{(COEF_W-K_W){k_fld[K_W-1]}}, k_fld};
    assign coef_frac = {1'b0, m_fld, {FRAC_SHIFT{1'b0}}} + k_ext;

    always_comb begin
        if (frac_mode) begin
            coef_mag = coef_frac[COEF_W-2:0];
            p_scaled = {p_fld, {FRAC_SHIFT{1'b0}}};
        end else begin
            coef_mag = {{(COEF_W-1-M_W){1'b0}}, m_fld};
            p_scaled = {{FRAC_SHIFT{1'b0}}, p_fld};
        end
    end

    assign coef_neg = frac_mode & coef_frac[COEF_W-1];
    assign p_zero   = (p_fld == '0);
    assign numer    = NUM_W'(ref_hz) * NUM_W'(coef_mag);
    assign denom    = {{(DEN_W-PS_W){1'b0}}, p_scaled} << s_fld;
endmodule

// File: rtl/pfc_shift_div.sv
module pfc_shift_div #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 29,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic [NUM_W-1:0] quotient,
    output logic             busy,
    output logic             fin
);
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             fin_q;

    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W:0]   diff;
    logic [DEN_W-1:0] rem_next;

    assign trial    = {rem_q, quo_q[NUM_W-1]};
    assign fits     = trial >= {1'b0, den_q};
    assign diff     = trial - {1'b0, den_q};
    assign rem_next = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load) begin
                quo_q  <= numer;
                rem_q  <= '0;
                den_q  <= denom;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= rem_next;
                quo_q <= {quo_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
    assign busy     = busy_q;
    assign fin      = fin_q;
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
    import pfc_pkg::*;
#(
    parameter int WORD_W     = PFC_WORD_W,
    parameter int M_W        = PFC_M_W,
    parameter int M_LSB      = PFC_M_LSB,
    parameter int P_W        = PFC_P_W,
    parameter int P_LSB      = PFC_P_LSB,
    parameter int S_W        = PFC_S_W,
    parameter int S_LSB      = PFC_S_LSB,
    parameter int K_W        = PFC_K_W,
    parameter int FRAC_SHIFT = PFC_FRAC_SHIFT,
    parameter int NUM_W      = PFC_NUM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              frac_mode,
    input  logic [WORD_W-1:0] div_word,
    input  logic [WORD_W-1:0] frac_word,
    input  logic [WORD_W-1:0] ref_hz,
    output logic [NUM_W-1:0]  freq_hz,
    output logic              done,
    output logic              err
);
    localparam int DEN_W = P_W + FRAC_SHIFT + (2**S_W) - 1;

    calc_state_e      state_q;
    calc_state_e      state_d;
    logic [NUM_W-1:0] numer;
    logic [DEN_W-1:0] denom;
    logic             p_zero;
    logic             coef_neg;
    logic             accept;
    logic             div_load;
    logic [NUM_W-1:0] quotient;
    logic             div_busy;
    logic             div_fin;
    logic [NUM_W-1:0] freq_q;
    logic             done_q;
    logic             err_q;

    pfc_operand_prep #(
        .WORD_W(WORD_W), .M_W(M_W), .M_LSB(M_LSB), .P_W(P_W), .P_LSB(P_LSB),
        .S_W(S_W), .S_LSB(S_LSB), .K_W(K_W), .FRAC_SHIFT(FRAC_SHIFT), .NUM_W(NUM_W)
    ) u_prep (
        .frac_mode(frac_mode),
        .div_word (div_word),
        .frac_word(frac_word),
        .ref_hz   (ref_hz),
        .numer    (numer),
        .denom    (denom),
        .p_zero   (p_zero),
        .coef_neg (coef_neg)
    );

    assign accept   = (state_q == CALC_IDLE) && start;
    assign div_load = accept && !p_zero && !coef_neg;

    pfc_shift_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (div_load),
        .numer   (numer),
        .denom   (denom),
        .quotient(quotient),
        .busy    (div_busy),
        .fin     (div_fin)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CALC_IDLE:   if (div_load) state_d = CALC_DIVIDE;
            CALC_DIVIDE: if (div_fin)  state_d = CALC_IDLE;
            default:     state_d = CALC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CALC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                CALC_IDLE: begin
                    if (accept && p_zero) begin
                        freq_q <= '0;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else if (accept && coef_neg) begin
                        freq_q <= '0;
                        done_q <= 1'b1;
                        err_q  <= 1'b0;
                    end
                end
                CALC_DIVIDE: begin
                    if (div_fin) begin
                        freq_q <= quotient;
                        done_q <= 1'b1;
                        err_q  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign freq_hz = freq_q;
    assign done    = done_q;
    assign err     = err_q;
endmodule

// File: rtl/pfc_calc_checker.sv
module pfc_calc_checker
    import pfc_pkg::*;
#(
    parameter int NUM_W = PFC_NUM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  calc_state_e      state_q,
    input  logic             p_zero,
    input  logic             coef_neg,
    input  logic             div_load,
    input  logic             div_busy,
    input  logic             div_fin,
    input  logic [NUM_W-1:0] freq_hz,
    input  logic             done,
    input  logic             err
);
    assert_fault_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CALC_IDLE && start && p_zero) |=> (done && err && freq_hz == '0));

    assert_negative_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CALC_IDLE && start && !p_zero && coef_neg) |=> (done && !err && freq_hz == '0));

    assert_launch_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> (div_busy && !done));

    assert_finish_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_fin |=> (done && !err));

    assert_done_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == CALC_IDLE));

    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CALC_DIVIDE && !div_fin) |=> (state_q == CALC_DIVIDE && !done));

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(freq_hz) && $stable(err)));
endmodule

bind pll_freq_calc pfc_calc_checker #(.NUM_W(NUM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .state_q (state_q),
    .p_zero  (p_zero),
    .coef_neg(coef_neg),
    .div_load(div_load),
    .div_busy(div_busy),
    .div_fin (div_fin),
    .freq_hz (freq_hz),
    .done    (done),
    .err     (err)
);

// File: tb/pll_freq_calc_bench.sv
module pll_freq_calc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        frac_mode = 1'b0;
    logic [31:0] div_word = '0;
    logic [31:0] frac_word = '0;
    logic [31:0] ref_hz = '0;
    logic [63:0] freq_hz;
    logic        done;
    logic        err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    string cur_tag = "R8";
    string act_tag = "R8";

    // behavioural model state (value expected after each edge)
    bit      m_done = 1'b0;
    bit      m_err = 1'b0;
    longint  m_freq = 0;
    bit      m_busy = 1'b0;
    int      m_cnt = 0;
    longint  m_pend = 0;

    always #5 clk = ~clk;

    pll_freq_calc u_pll_freq_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .frac_mode(frac_mode),
        .div_word(div_word), .frac_word(frac_word), .ref_hz(ref_hz),
        .freq_hz(freq_hz), .done(done), .err(err)
    );

    function automatic longint expect_f(bit mode, logic [31:0] dw, logic [31:0] fw, logic [31:0] rf);
        longint m, p, s, k, coef, den;
        m = longint'(dw[21:12]);
        p = longint'(dw[9:4]);
        s = longint'(dw[2:0]);
        k = longint'($signed(fw[15:0]));
        coef = mode ? (m * 65536 + k) : m;
        den  = (mode ? p * 65536 : p) << s;
        return (longint'(rf) * coef) / den;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_done = 0; m_err = 0; m_freq = 0; m_busy = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_err = 0; m_freq = m_pend;
                end
            end else if (start) begin
                act_tag = cur_tag;
                if (div_word[9:4] == 6'd0) begin
                    m_done = 1; m_err = 1; m_freq = 0;
                end else if (frac_mode &&
                             (longint'(div_word[21:12]) * 65536 + longint'($signed(frac_word[15:0]))) < 0) begin
                    m_done = 1; m_err = 0; m_freq = 0;
                end else begin
                    m_busy = 1; m_cnt = 65;
                    m_pend = expect_f(frac_mode, div_word, frac_word, ref_hz);
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            tests++;
            if (done !== m_done || err !== m_err || freq_hz !== 64'(m_freq)) begin
                fails++;
                $display("FAIL %s: done=%0b err=%0b freq=%0d expected done=%0b err=%0b freq=%0d",
                         act_tag, done, err, freq_hz, m_done, m_err, m_freq);
            end
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic fire(string tag, bit mode, logic [31:0] dw, logic [31:0] fw, logic [31:0] rf);
        @(negedge clk);
        cur_tag = tag; frac_mode = mode; div_word = dw; frac_word = fw; ref_hz = rf;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        div_word = 32'hFFFF_FFFF; frac_word = 32'hFFFF_FFFF; ref_hz = 32'h5A5A_5A5A;
    endtask

    function automatic logic [31:0] dword(int m, int p, int s);
        return (32'(m) << 12) | (32'(p) << 4) | 32'(s);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (done !== 1'b0 || err !== 1'b0 || freq_hz !== 64'd0) begin
            fails++;
            $display("FAIL R8 reset: done=%0b err=%0b freq=%0d expected 0 0 0", done, err, freq_hz);
        end
        rst_n = 1'b1;

        fire("R3", 1'b1, dword(173, 2, 1), 32'd16384, 32'd24000000);   // 1039500000
        repeat (70) @(negedge clk);
        fire("R3", 1'b1, dword(262, 2, 3), 32'd9437, 32'd24000000);
        repeat (70) @(negedge clk);
        fire("R2", 1'b0, dword(225, 3, 0), 32'd12345, 32'd24000000);    // 1800000000, K ignored
        repeat (70) @(negedge clk);
        fire("R1", 1'b0, dword(225, 3, 0) | 32'hFFC0_0C08, 32'hABCD_0000, 32'd24000000);
        repeat (70) @(negedge clk);
        fire("R1", 1'b1, dword(361, 3, 3) | 32'hFFC0_0C08, 32'h1234_0000 | 32'd17511, 32'd24000000);
        repeat (70) @(negedge clk);
        fire("R3", 1'b1, dword(100, 1, 0), 32'h0000_8000, 32'd24000000); // negative K
        repeat (70) @(negedge clk);
        fire("R9", 1'b1, dword(1023, 1, 0), 32'd32767, 32'hFFFF_FFFF);
        repeat (70) @(negedge clk);
        fire("R4", 1'b0, dword(7, 63, 7), 32'd0, 32'd1000000);
        repeat (70) @(negedge clk);
        fire("R5", 1'b1, dword(200, 0, 1), 32'd5, 32'd24000000);
        repeat (5) @(negedge clk);
        fire("R6", 1'b1, dword(0, 2, 0), 32'h0000_FFFF, 32'd24000000);   // M=0, K=-1
        repeat (5) @(negedge clk);
        fire("R6", 1'b0, dword(0, 2, 0), 32'h0000_FFFF, 32'd24000000);   // integer: result 0 via divide
        repeat (70) @(negedge clk);

        // R7: a zero-P start in mid-division must be ignored
        fire("R7", 1'b0, dword(300, 3, 1), 32'd0, 32'd24000000);
        repeat (10) @(negedge clk);
        fire("R7", 1'b0, dword(300, 0, 1), 32'd0, 32'd24000000);
        repeat (70) @(negedge clk);

        // R7: starts held on the edges around the report
        fire("R7", 1'b1, dword(250, 2, 2), 32'd0, 32'd24000000);
        repeat (63) @(negedge clk);
        cur_tag = "R7"; frac_mode = 1'b0; div_word = dword(350, 3, 2); ref_hz = 32'd24000000;
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (70) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule